// File: doc/BRIEF.md
# Baseline-Subtracted Pulse Integrator

This block sits behind the ADC of one beam-loss channel. It takes a stream of signed 16-bit samples (nominally 100 kHz, so 100 samples per millisecond) and, for each beam pulse marked by a trigger, returns the area under the pulse with the detector's standing offset removed.

The offset is estimated from the samples that came just before the trigger. A circular history always holds the latest `BASE_LEN` samples, along with their running sum. At the trigger that sum is frozen as the baseline, so the block does not have to wait for a pre-pulse window to elapse. The pulse window that follows is either two or three times the baseline length (2 ms or 3 ms at the default of 100 samples). Because the ratio is a whole number, the correction is the pulse sum minus the baseline sum times 2 or 3, and no divider is needed.

Each per-pulse result is also added into a multi-pulse accumulator. When a programmed number of pulses has been summed, the accumulator presents the total and the pulse count, then starts a new set. Division by the count and any calibration to physical units are left to downstream logic.

Top module: `loss_pulse_integrator`

Both outputs are valid/ready streams. A result stays on its port, unchanged, until it is taken. While either output holds a result that has not been taken, the sample input deasserts `s_ready`. No sample is lost and no result is overwritten. The trigger and the configuration pins are plain levels sampled on each clock.

## Requirements
- R1: The baseline of a pulse is the sum of the `BASE_LEN` samples accepted before the trigger cycle. A sample accepted in the same cycle as the trigger is the first sample of the pulse window.
- R2: `cfg_long` is sampled with the trigger. A value of 0 selects a window of 2×`BASE_LEN` samples with a baseline multiplier of 2. A value of 1 selects 3×`BASE_LEN` samples with a multiplier of 3.
- R3: `res_data` is the two's-complement sum of the pulse-window samples minus the multiplier times the baseline. It is exact for all-extreme inputs (for example a full-scale positive baseline with a full-scale negative pulse).
- R4: Until `BASE_LEN` samples have been accepted after reset, a trigger is ignored and no result is produced.
- R5: A trigger that arrives while a window is open does not disturb that window. It sets `overrun`, which stays at 1 until reset.
- R6: After each group of `cfg_pulses` results (a value of 0 counts as 1), `acc_valid` presents `acc_sum` and `acc_count` (equal to the group size), and the accumulator restarts from zero.
- R7: While `res_valid` or `acc_valid` is high and not accepted, that output holds its data and `s_ready` is 0.
- R8: After reset, `res_valid`, `acc_valid` and `overrun` are 0 and `s_ready` is 1.
- R9: A trigger in a cycle with no sample accepted opens the window. The window's first sample is the next sample accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| s_data | input | SAMPLE_W | Signed ADC sample |
| trig | input | 1 | Pulse trigger, one cycle |
| cfg_long | input | 1 | 0: window 2×BASE_LEN, 1: window 3×BASE_LEN |
| cfg_pulses | input | CNT_W | Pulses per accumulation group (0 counts as 1) |
| res_valid | output | 1 | Per-pulse result present |
| res_ready | input | 1 | Downstream takes per-pulse result |
| res_data | output | RES_W | Signed baseline-corrected integral |
| acc_valid | output | 1 | Accumulated group present |
| acc_ready | input | 1 | Downstream takes accumulated group |
| acc_sum | output | ACC_W | Signed sum over the group |
| acc_count | output | CNT_W | Pulses in the group |
| overrun | output | 1 | Sticky: a trigger arrived inside an open window |

## Verification
The bench builds the block with `BASE_LEN` = 5 and `MAX_PULSES` = 15. This gives windows of 10 and 15 samples and a 4-bit pulse count. With these values, many complete pulses, the filling of the history, trigger collisions and several accumulation groups all fit in a short run. The all-extreme case checks the derived result width at its edge. The window and history logic is the same as at the default size, scaled down.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  // Window span selection, latched with each trigger.
  typedef enum logic {
    SPAN_X2 = 1'b0,
    SPAN_X3 = 1'b1
  } span_t;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;
endpackage

// File: rtl/lpi_history.sv
module lpi_history #(
  parameter int SAMPLE_W = 16,
  parameter int BASE_LEN = 100,
  parameter int SUM_W    = 23
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SUM_W-1:0]    base_sum,
  output logic                       full
);
  localparam int PTR_W  = (BASE_LEN > 1) ? $clog2(BASE_LEN) : 1;
  localparam int FILL_W = $clog2(BASE_LEN + 1);

  logic signed [SAMPLE_W-1:0] ring [BASE_LEN];
  logic [PTR_W-1:0]           wptr;
  logic [FILL_W-1:0]          fill;
  logic signed [SAMPLE_W-1:0] oldest;

  assign full   = (fill == FILL_W'(BASE_LEN));
  // Until the ring is full the slot being written holds nothing counted.
  assign oldest = full ? ring[wptr] : '0;

  always_ff @(posedge clk) begin
    if (push) ring[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      fill     <= '0;
      base_sum <= '0;
    end else if (push) begin
      base_sum <= base_sum + SUM_W'(din) - SUM_W'(oldest);
      wptr     <= (wptr == PTR_W'(BASE_LEN - 1)) ? '0 : wptr + 1'b1;
      if (!full) fill <= fill + 1'b1;
    end
  end

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full); // R4
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (fill == $past(fill) + 1'b1)); // R4
endmodule

// File: rtl/lpi_window.sv
module lpi_window
  import lpi_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int BASE_LEN = 100,
  parameter int BASE_W   = 23,
  parameter int RES_W    = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic signed [SAMPLE_W-1:0] din,
  input  logic                       trig,
  input  logic                       hist_full,
  input  logic signed [BASE_W-1:0]   base_sum,
  input  logic                       cfg_long,
  input  logic                       res_ready,
  output logic                       res_valid,
  output logic signed [RES_W-1:0]    res_data,
  output logic                       close_now,
  output logic signed [RES_W-1:0]    res_next,
  output logic                       overrun
);
  localparam int LEN_X2 = 2 * BASE_LEN;
  localparam int LEN_X3 = 3 * BASE_LEN;
  localparam int CNT_W  = $clog2(LEN_X3 + 1);

  win_state_t               state;
  logic [CNT_W-1:0]         cnt;
  logic signed [RES_W-1:0]  psum;
  logic signed [BASE_W-1:0] base_hold;
  span_t                    span_hold;

  logic                     trig_ok;
  logic                     in_win;
  logic [CNT_W-1:0]         cur_cnt;
  logic signed [RES_W-1:0]  cur_psum;
  logic signed [BASE_W-1:0] cur_base;
  span_t                    cur_span;
  logic [CNT_W-1:0]         last_idx;
  logic signed [RES_W-1:0]  base_ext;
  logic signed [RES_W-1:0]  base_scaled;
  logic signed [RES_W-1:0]  din_ext;

  assign trig_ok  = trig && (state == WIN_IDLE) && hist_full;
  assign in_win   = (state == WIN_OPEN) || trig_ok;
  assign cur_cnt  = trig_ok ? '0 : cnt;
  assign cur_psum = trig_ok ? '0 : psum;
  assign cur_base = trig_ok ? base_sum : base_hold;
  assign cur_span = trig_ok ? span_t'(cfg_long) : span_hold;

  always_comb begin
    last_idx = (cur_span == SPAN_X3) ? CNT_W'(LEN_X3 - 1) : CNT_W'(LEN_X2 - 1);
    base_ext = RES_W'(cur_base);
    if (cur_span == SPAN_X3) base_scaled = (base_ext <<< 1) + base_ext;
    else                     base_scaled = base_ext <<< 1;
  end

  assign din_ext   = RES_W'(din);
  assign close_now = push && in_win && (cur_cnt == last_idx);
  assign res_next  = cur_psum + din_ext - base_scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WIN_IDLE;
      cnt       <= '0;
      psum      <= '0;
      base_hold <= '0;
      span_hold <= SPAN_X2;
      overrun   <= 1'b0;
    end else begin
      if (trig && (state == WIN_OPEN)) overrun <= 1'b1;
      if (trig_ok) begin
        base_hold <= base_sum;
        span_hold <= span_t'(cfg_long);
      end
      if (close_now) begin
        state <= WIN_IDLE;
        cnt   <= '0;
        psum  <= '0;
      end else begin
        if (trig_ok) state <= WIN_OPEN;
        if (push && in_win) begin
          cnt  <= cur_cnt + 1'b1;
          psum <= cur_psum + din_ext;
        end else if (trig_ok) begin
          cnt  <= '0;
          psum <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (close_now) begin
      res_valid <= 1'b1;
      res_data  <= res_next;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    close_now |-> hist_full); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R5
  AST_TRIG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && state == WIN_OPEN) |=> overrun); // R5
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R7
endmodule

// File: rtl/lpi_accum.sv
module lpi_accum #(
  parameter int RES_W = 26,
  parameter int CNT_W = 12,
  parameter int ACC_W = 38
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add,
  input  logic signed [RES_W-1:0] value,
  input  logic [CNT_W-1:0]        cfg_pulses,
  input  logic                    acc_ready,
  output logic                    acc_valid,
  output logic signed [ACC_W-1:0] acc_sum,
  output logic [CNT_W-1:0]        acc_count
);
  logic signed [ACC_W-1:0] run_sum;
  logic [CNT_W-1:0]        run_n;
  logic [CNT_W-1:0]        target;
  logic [CNT_W-1:0]        n_next;
  logic signed [ACC_W-1:0] sum_next;
  logic                    group_end;

  assign target    = (cfg_pulses == '0) ? CNT_W'(1) : cfg_pulses;
  assign n_next    = run_n + 1'b1;
  assign sum_next  = run_sum + ACC_W'(value);
  assign group_end = (n_next >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sum   <= '0;
      run_n     <= '0;
      acc_valid <= 1'b0;
      acc_sum   <= '0;
      acc_count <= '0;
    end else if (add) begin
      if (group_end) begin
        acc_valid <= 1'b1;
        acc_sum   <= sum_next;
        acc_count <= n_next;
        run_sum   <= '0;
        run_n     <= '0;
      end else begin
        run_sum <= sum_next;
        run_n   <= n_next;
        if (acc_ready) acc_valid <= 1'b0;
      end
    end else if (acc_ready) begin
      acc_valid <= 1'b0;
    end
  end

  AST_ACC_COUNT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_count != '0)); // R6
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_sum) && $stable(acc_count))); // R7
endmodule

// File: rtl/loss_pulse_integrator.sv
module loss_pulse_integrator #(
  parameter int SAMPLE_W   = 16,
  parameter int BASE_LEN   = 100,
  parameter int MAX_PULSES = 3600,
  localparam int CNT_W  = $clog2(MAX_PULSES + 1),
  localparam int BASE_W = SAMPLE_W + $clog2(BASE_LEN + 1),
  localparam int RES_W  = SAMPLE_W + $clog2(3 * BASE_LEN + 1) + 1,
  localparam int ACC_W  = RES_W + CNT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_data,
  input  logic                       trig,
  input  logic                       cfg_long,
  input  logic [CNT_W-1:0]           cfg_pulses,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic signed [RES_W-1:0]    res_data,
  output logic                       acc_valid,
  input  logic                       acc_ready,
  output logic signed [ACC_W-1:0]    acc_sum,
  output logic [CNT_W-1:0]           acc_count,
  output logic                       overrun
);
  logic                     push;
  logic                     hist_full;
  logic signed [BASE_W-1:0] base_sum;
  logic                     close_now;
  logic signed [RES_W-1:0]  res_next;

  assign s_ready = !(res_valid && !res_ready) && !(acc_valid && !acc_ready);
  assign push    = s_valid && s_ready;

  lpi_history #(
    .SAMPLE_W(SAMPLE_W), .BASE_LEN(BASE_LEN), .SUM_W(BASE_W)
  ) u_hist (
    .clk(clk), .rst_n(rst_n), .push(push), .din(s_data),
    .base_sum(base_sum), .full(hist_full)
  );

  lpi_window #(
    .SAMPLE_W(SAMPLE_W), .BASE_LEN(BASE_LEN), .BASE_W(BASE_W), .RES_W(RES_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .push(push), .din(s_data), .trig(trig),
    .hist_full(hist_full), .base_sum(base_sum), .cfg_long(cfg_long),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data),
    .close_now(close_now), .res_next(res_next), .overrun(overrun)
  );

  lpi_accum #(
    .RES_W(RES_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .add(close_now), .value(res_next),
    .cfg_pulses(cfg_pulses), .acc_ready(acc_ready), .acc_valid(acc_valid),
    .acc_sum(acc_sum), .acc_count(acc_count)
  );

  AST_STALL_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_valid && !res_ready) || (acc_valid && !acc_ready)) |-> !s_ready); // R7
  AST_NO_PUSH_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid); // R7
endmodule

// File: tb/tb_loss_pulse_integrator.sv
`timescale 1ns/1ps
module tb_loss_pulse_integrator;
  localparam int SW   = 16;
  localparam int BL   = 5;
  localparam int MAXP = 15;
  localparam int CW   = $clog2(MAXP + 1);
  localparam int RW   = SW + $clog2(3 * BL + 1) + 1;
  localparam int AW   = RW + CW;

  logic clk = 0;
  logic rst_n = 0;
  logic s_valid = 0;
  logic s_ready;
  logic signed [SW-1:0] s_data = '0;
  logic trig = 0;
  logic cfg_long = 0;
  logic [CW-1:0] cfg_pulses = CW'(1);
  logic res_valid, acc_valid, overrun;
  logic res_ready = 1;
  logic acc_ready = 1;
  logic signed [RW-1:0] res_data;
  logic signed [AW-1:0] acc_sum;
  logic [CW-1:0] acc_count;

  always #2.5 clk = ~clk;

  loss_pulse_integrator #(.SAMPLE_W(SW), .BASE_LEN(BL), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .trig(trig), .cfg_long(cfg_long), .cfg_pulses(cfg_pulses),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_sum(acc_sum),
    .acc_count(acc_count), .overrun(overrun)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Scoreboard queues
  longint exp_res_q[$];
  string  res_tag_q[$];
  longint exp_acc_q[$];
  int     exp_cnt_q[$];
  string  acc_tag_q[$];

  // Reference model state
  int     hist_q[$];
  bit     m_open = 0;
  int     m_cnt, m_len, m_k;
  longint m_psum, m_base, m_run;
  int     m_n = 0;
  string  cur_tag = "R3";

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(bit samp, int d, bit tr);
    if (tr) begin
      if (m_open) begin
      end else if (hist_q.size() == BL) begin
        m_open = 1; m_cnt = 0; m_psum = 0; m_base = 0;
        foreach (hist_q[i]) m_base += hist_q[i];
        m_k = cfg_long ? 3 : 2;
        m_len = m_k * BL;
      end
    end
    if (samp) begin
      if (m_open) begin
        m_psum += d; m_cnt++;
        if (m_cnt == m_len) begin
          longint r;
          int tgt;
          r = m_psum - m_k * m_base;
          m_open = 0;
          exp_res_q.push_back(r); res_tag_q.push_back(cur_tag);
          tgt = (cfg_pulses == 0) ? 1 : int'(cfg_pulses);
          m_run += r; m_n++;
          if (m_n >= tgt) begin
            exp_acc_q.push_back(m_run); exp_cnt_q.push_back(m_n);
            acc_tag_q.push_back("R6");
            m_run = 0; m_n = 0;
          end
        end
      end
      hist_q.push_back(d);
      if (hist_q.size() > BL) void'(hist_q.pop_front());
    end
  endtask

  task automatic drive(int d, bit tr, bit v);
    @(posedge clk); #1;
    s_valid = v; s_data = SW'(d); trig = tr;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    model_step(v, d, tr);
    #1 s_valid = 0; trig = 0;
  endtask

  // Monitor: compare outputs as they are handed over.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_res_q.size() == 0) check(0, "R4 unexpected result", longint'(res_data), 0);
      else begin
        longint e; string t;
        e = exp_res_q.pop_front(); t = res_tag_q.pop_front();
        check(longint'(res_data) == e, t, longint'(res_data), e);
      end
    end
    if (rst_n && acc_valid && acc_ready) begin
      if (exp_acc_q.size() == 0) check(0, "R6 unexpected group", longint'(acc_sum), 0);
      else begin
        longint e; int c; string t;
        e = exp_acc_q.pop_front(); c = exp_cnt_q.pop_front(); t = acc_tag_q.pop_front();
        check(longint'(acc_sum) == e, t, longint'(acc_sum), e);
        check(int'(acc_count) == c, "R6 count", longint'(acc_count), c);
      end
    end
  end

  bit finished = 0;
  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check(s_ready == 1, "R8 s_ready", s_ready, 1);
    check(res_valid == 0, "R8 res_valid", res_valid, 0);
    check(acc_valid == 0, "R8 acc_valid", acc_valid, 0);
    check(overrun == 0, "R8 overrun", overrun, 0);
    rst_n = 1;

    // R4: trigger before history is full is ignored
    cur_tag = "R4";
    for (int i = 0; i < 3; i++) drive(100 + i, 0, 1);
    drive(103, 1, 1);
    for (int i = 0; i < 16; i++) drive(50 - i, 0, 1);
    repeat (2) @(negedge clk);
    check(exp_res_q.size() == 0 && res_valid == 0, "R4 no result", res_valid, 0);
    check(overrun == 0, "R4 overrun", overrun, 0);

    // R1/R2/R3 short window, varied data, trigger with a sample
    cur_tag = "R1"; cfg_long = 0;
    for (int i = 0; i < 5; i++) drive(i * 1000 - 2000, 0, 1);
    drive(77, 1, 1);
    for (int i = 0; i < 12; i++) drive((i * 37) % 200 - 100, 0, 1);

    // R2 long window
    cur_tag = "R2"; cfg_long = 1;
    drive(-5, 1, 1);
    cfg_long = 0;  // latched at trigger, change must not matter
    for (int i = 0; i < 17; i++) drive(i * 311 - 900, 0, 1);

    // R5: trigger inside open window
    cur_tag = "R5";
    drive(10, 1, 1);
    for (int i = 0; i < 4; i++) drive(20 + i, 0, 1);
    drive(30, 1, 1);
    @(negedge clk);
    check(overrun == 1, "R5 overrun set", overrun, 1);
    for (int i = 0; i < 8; i++) drive(-40 + i, 0, 1);
    @(negedge clk);
    check(overrun == 1, "R5 overrun sticky", overrun, 1);

    // R6: groups of three, then cfg 0 meaning one
    cur_tag = "R6"; cfg_pulses = CW'(3);
    for (int p = 0; p < 3; p++) begin
      drive(p * 7, 1, 1);
      for (int i = 0; i < 11; i++) drive(i * 13 - p * 50, 0, 1);
    end
    cfg_pulses = '0;
    drive(1, 1, 1);
    for (int i = 0; i < 11; i++) drive(-i * 99, 0, 1);
    cfg_pulses = CW'(1);

    // R3 extremes: full-scale positive baseline, full-scale negative long pulse
    cur_tag = "R3";
    for (int i = 0; i < 5; i++) drive(32767, 0, 1);
    cfg_long = 1;
    drive(-32768, 1, 1);
    cfg_long = 0;
    for (int i = 0; i < 14; i++) drive(-32768, 0, 1);

    // R9: trigger with no sample present
    cur_tag = "R9";
    drive(0, 1, 0);
    for (int i = 0; i < 11; i++) drive(i * 500 - 2500, 0, 1);

    // R7: back-pressure
    cur_tag = "R7";
    res_ready = 0; acc_ready = 0;
    drive(3, 1, 1);
    for (int i = 0; i < 9; i++) drive(i + 8, 0, 1);
    @(negedge clk);
    check(res_valid == 1, "R7 res held", res_valid, 1);
    check(s_ready == 0, "R7 s_ready low", s_ready, 0);
    begin
      longint held;
      held = longint'(res_data);
      repeat (3) @(negedge clk);
      check(longint'(res_data) == held, "R7 data stable", longint'(res_data), held);
      check(s_ready == 0, "R7 still stalled", s_ready, 0);
    end
    res_ready = 1; acc_ready = 1;
    repeat (2) @(negedge clk);
    check(s_ready == 1, "R7 released", s_ready, 1);

    repeat (4) @(negedge clk);
    check(exp_res_q.size() == 0, "R3 results drained", exp_res_q.size(), 0);
    check(exp_acc_q.size() == 0, "R6 groups drained", exp_acc_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule